// File: doc/BRIEF.md
# Toggle-Serviced Software Watchdog

This block watches processor firmware for signs of life. Firmware proves it is alive by flipping a write-only service bit. Each write carries a data value, and only a write whose value differs from the bit currently held counts as a service. Writing the value already held does nothing. Firmware never reads the bit back, so it must keep its own copy of the level and write the inverse each time.

A counter measures clock cycles since the last service, or since the watchdog was enabled. When it reaches `TIMEOUT` cycles without a service, the block raises two strobes together for `PULSE_LEN` cycles. One strobe resets the processor core. The other zeroes both output-DAC data registers, so both analog outputs fall to 0 V. Nothing else is reset: the enable bit and the other peripheral settings keep their values. With the enable still set, timing starts again from zero when the pulse ends. The default `TIMEOUT` of 500000 gives 500 ms at a 1 MHz clock.

Top module: `toggle_wdog`

## Requirements
- R1: While `rst` (synchronous, active high) is asserted and in the first cycle after it is released, `core_rst` and `dac_clr` are 0, and the held service bit is 0.
- R2: While `wd_enable` is 0, no new pulse starts, however much time passes and whatever service writes occur.
- R3: Enabling starts the count from zero. The first pulse begins just after the `TIMEOUT`-th rising edge at which `wd_enable` is sampled 1 with no service in between, and not earlier.
- R4: A service event is a cycle with `svc_wr`=1 and `svc_data` different from the held bit. A 0-to-1 change and a 1-to-0 change both count. After a service, the next pulse begins just after the `TIMEOUT`-th edge that follows the edge sampling the write.
- R5: A write with `svc_data` equal to the held bit is not a service and does not move the deadline.
- R6: On a timeout, `core_rst` and `dac_clr` are both 1 in exactly the same `PULSE_LEN` consecutive cycles.
- R7: The pulse leaves `wd_enable` untouched. If it is still 1, the count restarts at zero, so the next pulse begins `TIMEOUT` cycles after the previous one ends.
- R8: Service writes made during a pulse neither shorten it nor move the next deadline.
- R9: Clearing `wd_enable` during a pulse does not cut the pulse short, and no later pulse follows while the enable stays 0.
- R10: A service sampled at the same edge on which the count would expire takes priority. No pulse starts, and the count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the timing base for the timeout |
| rst | input | 1 | Power-on reset, synchronous, active high |
| wd_enable | input | 1 | Watchdog enable bit from the control register |
| svc_wr | input | 1 | Write strobe for the service bit |
| svc_data | input | 1 | Value written to the service bit |
| core_rst | output | 1 | Reset pulse to the processor core |
| dac_clr | output | 1 | Clear strobe that zeroes both DAC data registers |

## Verification
A counter left at the wrong value, or a held service bit with the wrong level, shows at the ports as a reset pulse that starts too early, too late or not at all. Service-bit errors show as writes that restart the count when they should not, or fail to restart it when they should. The bench therefore measures every pulse's start to the exact cycle, measured from the enabling edge, the service edge or the end of the previous pulse. A wrong pulse-length counter shows within one pulse as a wrong `PULSE_LEN`, or as the two strobes disagreeing in some cycle. Each timing error becomes visible within one timeout period.

// File: rtl/twd_pkg.sv
package twd_pkg;

    typedef enum logic {
        TWD_RUN  = 1'b0,
        TWD_BITE = 1'b1
    } twd_state_e;

    typedef struct packed {
        logic core_rst;
        logic dac_clr;
    } twd_bite_t;

    localparam twd_bite_t TWD_BITE_OFF = '{core_rst: 1'b0, dac_clr: 1'b0};
    localparam twd_bite_t TWD_BITE_ON  = '{core_rst: 1'b1, dac_clr: 1'b1};

    // a write counts only when it changes the held level
    function automatic logic twd_is_service(logic wr, logic data, logic held);
        return wr && (data != held);
    endfunction

    function automatic int unsigned twd_width(int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/twd_svc_latch.sv
module twd_svc_latch
    import twd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic svc_wr,
    input  logic svc_data,
    output logic svc_event
);

    logic held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= 1'b0;
        end else if (svc_wr) begin
            held_q <= svc_data;
        end
    end

    assign svc_event = twd_is_service(svc_wr, svc_data, held_q);

endmodule

// File: rtl/twd_period_cnt.sv
module twd_period_cnt
    import twd_pkg::*;
#(
    parameter int unsigned TIMEOUT = 500000
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    output logic at_limit
);

    localparam int unsigned CW = twd_width(TIMEOUT);
    localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT - 1);

    logic [CW-1:0] cnt_q;

    assign at_limit = (cnt_q == LIMIT);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else if (at_limit) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/twd_bite_fsm.sv
module twd_bite_fsm
    import twd_pkg::*;
#(
    parameter int unsigned PULSE_LEN = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      expire,
    output logic      in_bite,
    output twd_bite_t bite
);

    localparam int unsigned PW = twd_width(PULSE_LEN);

    twd_state_e state_q;
    twd_state_e state_d;
    logic       last;

    generate
        if (PULSE_LEN == 1) begin : g_single
            assign last = 1'b1;
        end else begin : g_multi
            logic [PW-1:0] pc_q;
            always_ff @(posedge clk) begin
                if (rst || state_q != TWD_BITE) begin
                    pc_q <= '0;
                end else begin
                    pc_q <= pc_q + 1'b1;
                end
            end
            assign last = (pc_q == PW'(PULSE_LEN - 1));
        end
    endgenerate

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TWD_RUN:  if (expire) state_d = TWD_BITE;
            TWD_BITE: if (last)   state_d = TWD_RUN;
            default:              state_d = TWD_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= TWD_RUN;
            bite    <= TWD_BITE_OFF;
        end else begin
            state_q <= state_d;
            bite    <= (state_d == TWD_BITE) ? TWD_BITE_ON : TWD_BITE_OFF;
        end
    end

    assign in_bite = (state_q == TWD_BITE);

endmodule

// File: rtl/toggle_wdog.sv
module toggle_wdog
    import twd_pkg::*;
#(
    parameter int unsigned TIMEOUT   = 500000,
    parameter int unsigned PULSE_LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic wd_enable,
    input  logic svc_wr,
    input  logic svc_data,
    output logic core_rst,
    output logic dac_clr
);

    logic      svc_event;
    logic      at_limit;
    logic      in_bite;
    logic      expire;
    logic      cnt_clear;
    twd_bite_t bite;

    twd_svc_latch u_latch (
        .clk       (clk),
        .rst       (rst),
        .svc_wr    (svc_wr),
        .svc_data  (svc_data),
        .svc_event (svc_event)
    );

    // writes during a pulse are not services; the count stays at zero
    assign cnt_clear = !wd_enable || svc_event || in_bite;
    // a service on the limit edge wins over expiry
    assign expire    = wd_enable && !svc_event && !in_bite && at_limit;

    twd_period_cnt #(.TIMEOUT(TIMEOUT)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .clear    (cnt_clear),
        .at_limit (at_limit)
    );

    twd_bite_fsm #(.PULSE_LEN(PULSE_LEN)) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .expire  (expire),
        .in_bite (in_bite),
        .bite    (bite)
    );

    assign core_rst = bite.core_rst;
    assign dac_clr  = bite.dac_clr;

endmodule

// File: rtl/toggle_wdog_chk.sv
module toggle_wdog_chk #(
    parameter int unsigned TIMEOUT   = 500000,
    parameter int unsigned PULSE_LEN = 4
) (
    input logic clk,
    input logic rst,
    input logic wd_enable,
    input logic svc_wr,
    input logic svc_data,
    input logic core_rst,
    input logic dac_clr
);

    localparam int unsigned QW = $clog2(TIMEOUT + 2);
    localparam int unsigned LW = $clog2(PULSE_LEN + 2);

    logic          shadow_q;
    logic [QW-1:0] quiet_q;
    logic [LW-1:0] hi_len_q;
    logic          svc_seen;

    assign svc_seen = svc_wr && (svc_data != shadow_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= 1'b0;
        end else if (svc_wr) begin
            shadow_q <= svc_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !wd_enable || core_rst || svc_seen) begin
            quiet_q <= '0;
        end else if (quiet_q <= QW'(TIMEOUT)) begin
            quiet_q <= quiet_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !core_rst) begin
            hi_len_q <= '0;
        end else if (hi_len_q <= LW'(PULSE_LEN)) begin
            hi_len_q <= hi_len_q + 1'b1;
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!core_rst && !dac_clr));

    // R2
    disabled_no_bite_chk: assert property (@(posedge clk) disable iff (rst)
        (!wd_enable && !core_rst) |=> !core_rst);

    // R3 R4 R7 R10
    bite_on_time_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(core_rst) |-> (quiet_q == QW'(TIMEOUT)));

    // R4 R5
    no_late_bite_chk: assert property (@(posedge clk) disable iff (rst)
        quiet_q <= QW'(TIMEOUT));

    // R6 R8
    pulse_not_long_chk: assert property (@(posedge clk) disable iff (rst)
        core_rst |-> (hi_len_q < LW'(PULSE_LEN)));

    // R6 R9
    pulse_not_short_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(core_rst) |-> (hi_len_q == LW'(PULSE_LEN)));

endmodule

bind toggle_wdog toggle_wdog_chk #(
    .TIMEOUT   (TIMEOUT),
    .PULSE_LEN (PULSE_LEN)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wd_enable (wd_enable),
    .svc_wr    (svc_wr),
    .svc_data  (svc_data),
    .core_rst  (core_rst),
    .dac_clr   (dac_clr)
);

// File: tb/tb_toggle_wdog.sv
module tb_toggle_wdog;

    localparam int T = 20;
    localparam int P = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wd_enable = 1'b0;
    logic svc_wr = 1'b0;
    logic svc_data = 1'b0;
    logic core_rst;
    logic dac_clr;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;
    logic shadow  = 1'b0;

    always #10 clk = ~clk;

    toggle_wdog #(.TIMEOUT(T), .PULSE_LEN(P)) dut (
        .clk       (clk),
        .rst       (rst),
        .wd_enable (wd_enable),
        .svc_wr    (svc_wr),
        .svc_data  (svc_data),
        .core_rst  (core_rst),
        .dac_clr   (dac_clr)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic count_rise(input int limit, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!core_rst && n < limit);
    endtask

    task automatic svc_write(input logic v);
        svc_wr   = 1'b1;
        svc_data = v;
        @(negedge clk);
        svc_wr   = 1'b0;
        shadow   = v;
    endtask

    task automatic quiesce();
        wd_enable = 1'b0;
        svc_wr    = 1'b0;
        while (core_rst) @(negedge clk);
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        check(core_rst == 1'b0, "R1 core_rst after reset", int'(core_rst), 0);
        check(dac_clr == 1'b0, "R1 dac_clr after reset", int'(dac_clr), 0);
        // held bit is 0: writing 0 must not restart the count
        wd_enable = 1'b1;
        repeat (3) @(negedge clk);
        svc_write(1'b0);
        begin
            int n;
            count_rise(5 * T, n);
            check(n == T - 4, "R1 held bit zero after reset", n + 4, T);
        end
        quiesce();
    endtask

    task automatic t_disabled();
        int hi = 0;
        quiesce();
        for (int i = 0; i < 3 * T; i++) begin
            if (i % 7 == 3) svc_write(~shadow);
            else @(negedge clk);
            if (core_rst) hi++;
        end
        check(hi == 0, "R2 no pulse while disabled", hi, 0);
    endtask

    task automatic t_enable();
        int n;
        int m = 0;
        int mism = 0;
        quiesce();
        wd_enable = 1'b1;
        count_rise(5 * T, n);
        check(n == T, "R3 first pulse after enable", n, T);
        while (core_rst) begin
            if (dac_clr != core_rst) mism++;
            m++;
            @(negedge clk);
        end
        if (dac_clr != core_rst) mism++;
        check(m == P, "R6 pulse length", m, P);
        check(mism == 0, "R6 strobes agree", mism, 0);
        count_rise(5 * T, n);
        check(n == T, "R7 restart after pulse", n, T);
        quiesce();
    endtask

    task automatic t_toggle();
        int n;
        for (int k = 0; k < 2; k++) begin
            quiesce();
            wd_enable = 1'b1;
            repeat (7) @(negedge clk);
            svc_write(~shadow);
            count_rise(5 * T, n);
            check(n == T, shadow ? "R4 service on 0-to-1" : "R4 service on 1-to-0", n, T);
        end
        quiesce();
    endtask

    task automatic t_same();
        int n;
        quiesce();
        wd_enable = 1'b1;
        repeat (5) @(negedge clk);
        svc_write(shadow);
        count_rise(5 * T, n);
        check(n == T - 6, "R5 same-value write ignored", n + 6, T);
        quiesce();
    endtask

    task automatic t_bite_writes();
        int n;
        int m = 0;
        quiesce();
        wd_enable = 1'b1;
        count_rise(5 * T, n);
        while (core_rst) begin
            m++;
            svc_wr   = 1'b1;
            svc_data = ~shadow;
            shadow   = ~shadow;
            @(negedge clk);
        end
        svc_wr = 1'b0;
        check(m == P, "R8 pulse length with writes", m, P);
        count_rise(5 * T, n);
        check(n == T, "R8 deadline after pulse with writes", n, T);
        quiesce();
    endtask

    task automatic t_en_off();
        int n;
        int m = 0;
        int hi = 0;
        quiesce();
        wd_enable = 1'b1;
        count_rise(5 * T, n);
        wd_enable = 1'b0;
        while (core_rst) begin
            m++;
            @(negedge clk);
        end
        check(m == P, "R9 pulse completes after disable", m, P);
        for (int i = 0; i < 3 * T; i++) begin
            @(negedge clk);
            if (core_rst) hi++;
        end
        check(hi == 0, "R9 no pulse after disable", hi, 0);
    endtask

    task automatic t_race();
        int n;
        quiesce();
        wd_enable = 1'b1;
        repeat (T - 1) @(negedge clk);
        svc_write(~shadow);
        check(core_rst == 1'b0, "R10 service wins on limit edge", int'(core_rst), 0);
        count_rise(5 * T, n);
        check(n == T, "R10 count restarted", n, T);
        quiesce();
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_enable();
        t_toggle();
        t_same();
        t_bite_writes();
        t_en_off();
        t_race();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            summary();
            $finish;
        end
    end

endmodule